// File: doc/BRIEF.md
# Floating-Point Register Stack Controller

This block owns an eight-entry file of 80-bit floating-point registers and presents it as a circular stack. A 3-bit top pointer names the current head. Requests name a stack position ST(i), which the block turns into a physical register index. It then reads or writes that register and moves the pointer. Each register carries a valid tag. The block uses the tags to catch a push that would overwrite live data (overflow) and a use of an empty position (underflow). A request that faults changes nothing.

The arithmetic unit, format conversion and instruction decode sit outside the block. A computed result enters on `wr_data`, together with an opcode that says where it goes. There are two combined forms. The classic form writes ST(1) and then pops, so the result ends up on top. The register-pop form writes ST(i) and then pops. One request is accepted in each clock cycle, and every result appears on the registered outputs one cycle later.

Top module: `fp_regstack`

## Requirements
- R1: After reset `top` is 0, all tags are clear, and `rd_valid`, `ovf_flag` and `unf_flag` are 0.
- R2: Position ST(i) is physical register (top + i) mod 8. A READ (opcode 3) of a tagged position returns that register on `rd_data` with `rd_valid` high.
- R3: A PUSH (opcode 1) first lowers the pointer by one, wrapping from 0 to 7. It then stores `wr_data` in the register now on top and sets that register's tag.
- R4: A POP (opcode 2) returns the top register, clears its tag and raises the pointer by one, wrapping from 7 to 0.
- R5: A PUSH whose target register is still tagged sets `ovf_flag`. It leaves the registers, the tags and the pointer unchanged.
- R6: A POP or READ of an untagged position sets `unf_flag`, keeps `rd_valid` low and changes no state.
- R7: A WRITE (opcode 4) stores `wr_data` in ST(slot) and sets its tag. It never faults and leaves the pointer alone.
- R8: A CLASSIC request (opcode 5) writes `wr_data` into ST(1), clears the tag of ST(0) and raises the pointer. Afterwards the result is the new ST(0). If ST(0) or ST(1) is empty, it sets `unf_flag` and changes nothing.
- R9: A REGISTER-POP request (opcode 6) writes `wr_data` into ST(slot) and then pops ST(0). With slot 0 the written value is discarded. If ST(0) or ST(slot) is empty, it sets `unf_flag` and changes nothing.
- R10: Opcodes 0 and 7, and any cycle with `op_valid` low, have no effect.
- R11: All outputs are registered. Each request's effects appear one clock after the edge that accepts it. `ovf_flag`, `unf_flag` and `rd_valid` are single-cycle pulses that are never raised together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Request present this cycle |
| op_code | input | 3 | Request opcode (see R3 to R10) |
| slot | input | 3 | Stack position i for READ, WRITE and REGISTER-POP |
| wr_data | input | 80 | Value to store |
| top | output | 3 | Current top pointer |
| tags | output | 8 | Valid tag per physical register |
| rd_data | output | 80 | Value from the last successful POP or READ |
| rd_valid | output | 1 | `rd_data` updated by the previous request |
| ovf_flag | output | 1 | Previous request was a faulting PUSH |
| unf_flag | output | 1 | Previous request touched an empty position |

## Verification
Every output of this block is due exactly one clock after the request is accepted. This holds for the pointer, the tags, the read data and both fault pulses. The bench presents each request on the falling edge and lets one rising edge accept it. It samples shortly after that edge and compares against a model updated by the same request. The flags are compared after every request, which also confirms that they fall again on the next cycle. Register contents are observed only through later READ and POP results, so a bad write shows up when the bench reads that register back.

// File: rtl/fpstk_pkg.sv
package fpstk_pkg;

    typedef enum logic [2:0] {
        OP_NOP     = 3'd0,
        OP_PUSH    = 3'd1,
        OP_POP     = 3'd2,
        OP_READ    = 3'd3,
        OP_WRITE   = 3'd4,
        OP_CLASSIC = 3'd5,
        OP_WRPOP   = 3'd6,
        OP_RSVD    = 3'd7
    } stk_op_e;

endpackage

// File: rtl/fpstk_slot_map.sv
// Turns a stack-relative position into a physical register index.
module fpstk_slot_map #(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic [PTR_W-1:0] base,
    input  logic [PTR_W-1:0] offset,
    output logic [PTR_W-1:0] idx
);
    localparam logic [PTR_W:0] DEPTH_W = (PTR_W+1)'(DEPTH);

    logic [PTR_W:0] sum;

    always_comb begin
        sum = {1'b0, base} + {1'b0, offset};
        if (sum >= DEPTH_W) begin
            idx = PTR_W'(sum - DEPTH_W);
        end else begin
            idx = sum[PTR_W-1:0];
        end
    end
endmodule

// File: rtl/fpstk_regfile.sv
// Register storage: one write port and one combinational read port.
module fpstk_regfile #(
    parameter int DATA_W = 80,
    parameter int DEPTH  = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [PTR_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PTR_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_comb begin
        for (int k = 0; k < DEPTH; k++) begin
            mem_d[k] = mem_q[k];
        end
        if (we) begin
            mem_d[widx] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < DEPTH; k++) begin
            if (!rst_n) begin
                mem_q[k] <= '0;
            end else begin
                mem_q[k] <= mem_d[k];
            end
        end
    end

    assign rdata = mem_q[ridx];
endmodule

// File: rtl/fp_regstack.sv
module fp_regstack
    import fpstk_pkg::*;
#(
    parameter int DATA_W = 80,
    parameter int DEPTH  = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic [PTR_W-1:0]  slot,
    input  logic [DATA_W-1:0] wr_data,
    output logic [PTR_W-1:0]  top,
    output logic [DEPTH-1:0]  tags,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              ovf_flag,
    output logic              unf_flag
);
    localparam logic [PTR_W-1:0] DOWN_ONE = PTR_W'(DEPTH - 1);
    localparam logic [PTR_W-1:0] UP_ONE   = PTR_W'(1);

    typedef struct packed {
        logic [PTR_W-1:0]  top;
        logic [DEPTH-1:0]  tag;
        logic [DATA_W-1:0] rd_data;
        logic              rd_valid;
        logic              ovf;
        logic              unf;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    stk_op_e          op;
    logic [PTR_W-1:0] sel_off;
    logic [PTR_W-1:0] sel_idx;
    logic [PTR_W-1:0] push_idx;
    logic [PTR_W-1:0] inc_idx;
    logic             rf_we;
    logic [PTR_W-1:0] rf_widx;
    logic [DATA_W-1:0] rf_rdata;

    assign op = stk_op_e'(op_code);

    // The POP read targets ST(0), CLASSIC targets ST(1), the rest take the slot input
    always_comb begin
        case (op)
            OP_POP:     sel_off = '0;
            OP_CLASSIC: sel_off = UP_ONE;
            default:    sel_off = slot;
        endcase
    end

    fpstk_slot_map #(.DEPTH(DEPTH)) u_map_sel (
        .base(ctl_q.top), .offset(sel_off), .idx(sel_idx));
    fpstk_slot_map #(.DEPTH(DEPTH)) u_map_push (
        .base(ctl_q.top), .offset(DOWN_ONE), .idx(push_idx));
    fpstk_slot_map #(.DEPTH(DEPTH)) u_map_inc (
        .base(ctl_q.top), .offset(UP_ONE), .idx(inc_idx));

    fpstk_regfile #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .we(rf_we), .widx(rf_widx), .wdata(wr_data),
        .ridx(sel_idx), .rdata(rf_rdata));

    always_comb begin
        ctl_d          = ctl_q;
        ctl_d.rd_valid = 1'b0;
        ctl_d.ovf      = 1'b0;
        ctl_d.unf      = 1'b0;
        rf_we          = 1'b0;
        rf_widx        = sel_idx;
        if (op_valid) begin
            case (op)
                OP_PUSH: begin
                    if (ctl_q.tag[push_idx]) begin
                        ctl_d.ovf = 1'b1;
                    end else begin
                        rf_we               = 1'b1;
                        rf_widx             = push_idx;
                        ctl_d.tag[push_idx] = 1'b1;
                        ctl_d.top           = push_idx;
                    end
                end
                OP_POP, OP_READ: begin
                    if (!ctl_q.tag[sel_idx]) begin
                        ctl_d.unf = 1'b1;
                    end else begin
                        ctl_d.rd_data  = rf_rdata;
                        ctl_d.rd_valid = 1'b1;
                        if (op == OP_POP) begin
                            ctl_d.tag[ctl_q.top] = 1'b0;
                            ctl_d.top            = inc_idx;
                        end
                    end
                end
                OP_WRITE: begin
                    rf_we              = 1'b1;
                    ctl_d.tag[sel_idx] = 1'b1;
                end
                OP_CLASSIC, OP_WRPOP: begin
                    if (!ctl_q.tag[ctl_q.top] || !ctl_q.tag[sel_idx]) begin
                        ctl_d.unf = 1'b1;
                    end else begin
                        rf_we                = 1'b1;
                        ctl_d.tag[ctl_q.top] = 1'b0;
                        ctl_d.top            = inc_idx;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign top      = ctl_q.top;
    assign tags     = ctl_q.tag;
    assign rd_data  = ctl_q.rd_data;
    assign rd_valid = ctl_q.rd_valid;
    assign ovf_flag = ctl_q.ovf;
    assign unf_flag = ctl_q.unf;

    // R3: an accepted push lowers the pointer by one with wrap
    assert_push_moves_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_PUSH && !ovf_flag_next_free())
        |=> top == PTR_W'(($past(top) + DEPTH - 1) % DEPTH));

    // R4: an accepted pop leaves the old top register untagged
    assert_pop_clears_tag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_POP && tags[top])
        |=> !tags[$past(top)]);

    // R5: a faulting push keeps the pointer and the tags
    assert_ovf_no_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |-> (top == $past(top) && tags == $past(tags)));

    // R6: an underflow keeps the pointer and the tags
    assert_unf_no_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
        unf_flag |-> (top == $past(top) && tags == $past(tags)));

    // R11: at most one result pulse per cycle
    assert_one_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_valid, ovf_flag, unf_flag}));

    function automatic logic ovf_flag_next_free();
        return tags[PTR_W'((top + DEPTH - 1) % DEPTH)];
    endfunction
endmodule

// File: tb/fp_regstack_tb.sv
module fp_regstack_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid;
    logic [2:0]  op_code;
    logic [2:0]  slot;
    logic [79:0] wr_data;
    logic [2:0]  top;
    logic [7:0]  tags;
    logic [79:0] rd_data;
    logic        rd_valid, ovf_flag, unf_flag;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    int          m_top;
    bit [7:0]    m_tag;
    logic [79:0] m_reg [8];
    logic [79:0] m_rd;

    always #2 clk = ~clk;

    fp_regstack u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .slot(slot), .wr_data(wr_data), .top(top), .tags(tags),
        .rd_data(rd_data), .rd_valid(rd_valid), .ovf_flag(ovf_flag),
        .unf_flag(unf_flag));

    task automatic check(string req, logic [79:0] act, logic [79:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [79:0] mk(int k);
        logic [31:0] v = 32'(k) * 32'h9E3779B1;
        return {16'hC3A5, v, ~v};
    endfunction

    task automatic do_op(int oc, int sl, logic [79:0] d, bit vld = 1);
        bit e_ovf = 0, e_unf = 0, e_rv = 0;
        int i, a;
        string req;
        @(negedge clk);
        op_valid = vld; op_code = 3'(oc); slot = 3'(sl); wr_data = d;
        i = (m_top + sl) % 8;
        req = "R10 no-op";
        if (vld) begin
            case (oc)
                1: begin
                    req = "R3 push";
                    a = (m_top + 7) % 8;
                    if (m_tag[a]) begin e_ovf = 1; req = "R5 overflow"; end
                    else begin m_reg[a] = d; m_tag[a] = 1; m_top = a; end
                end
                2: begin
                    req = "R4 pop";
                    if (!m_tag[m_top]) begin e_unf = 1; req = "R6 pop underflow"; end
                    else begin
                        m_rd = m_reg[m_top]; e_rv = 1; m_tag[m_top] = 0;
                        m_top = (m_top + 1) % 8;
                    end
                end
                3: begin
                    req = "R2 read slot";
                    if (!m_tag[i]) begin e_unf = 1; req = "R6 read underflow"; end
                    else begin m_rd = m_reg[i]; e_rv = 1; end
                end
                4: begin req = "R7 write"; m_reg[i] = d; m_tag[i] = 1; end
                5, 6: begin
                    if (oc == 5) begin i = (m_top + 1) % 8; req = "R8 classic"; end
                    else req = "R9 register-pop";
                    if (!m_tag[m_top] || !m_tag[i]) e_unf = 1;
                    else begin
                        m_reg[i] = d; m_tag[m_top] = 0; m_top = (m_top + 1) % 8;
                    end
                end
                default: ;
            endcase
        end
        @(posedge clk); #1;
        op_valid = 0;
        // R11: every output compared one edge after acceptance
        check({req, " top"}, 80'(top), 80'(m_top));
        check({req, " tags"}, 80'(tags), 80'(m_tag));
        check({req, " R11 ovf pulse"}, 80'(ovf_flag), 80'(e_ovf));
        check({req, " R11 unf pulse"}, 80'(unf_flag), 80'(e_unf));
        check({req, " R11 rd_valid"}, 80'(rd_valid), 80'(e_rv));
        if (e_rv) check({req, " rd_data"}, rd_data, m_rd);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf = 16'hACE1;
        rst_n = 0; op_valid = 0; op_code = 0; slot = 0; wr_data = '0;
        m_top = 0; m_tag = '0; m_rd = '0;
        for (int k = 0; k < 8; k++) m_reg[k] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        @(posedge clk); #1;
        check("R1 reset top", 80'(top), 80'(0));
        check("R1 reset tags", 80'(tags), 80'(0));
        check("R1 reset flags", 80'({rd_valid, ovf_flag, unf_flag}), 80'(0));

        // Fill through the 0->7 wrap, then one push too many
        for (int k = 0; k < 9; k++) do_op(1, 0, mk(k));
        for (int s = 0; s < 8; s++) do_op(3, s, '0);
        do_op(0, 0, mk(99));
        do_op(7, 3, mk(98));
        do_op(1, 0, mk(97), 0);
        for (int k = 0; k < 9; k++) do_op(2, 0, '0);
        do_op(3, 2, '0);
        do_op(5, 0, mk(50));
        do_op(1, 0, mk(51));
        do_op(5, 0, mk(52));
        do_op(1, 0, mk(53));
        do_op(5, 0, mk(54));
        do_op(3, 0, '0);
        do_op(2, 0, '0);
        // Register-pop with every slot
        for (int s = 0; s < 8; s++) begin
            for (int k = 0; k < 8; k++) do_op(4, k, mk(100 + 8 * s + k));
            do_op(6, s, mk(200 + s));
            for (int k = 0; k < 8; k++) do_op(3, k, '0);
            for (int k = 0; k < 8; k++) do_op(2, 0, '0);
        end
        do_op(6, 3, mk(300));
        // Pseudo-random mix with bias toward pushes
        for (int n = 0; n < 4000; n++) begin
            int oc;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            oc = int'(lf[2:0]);
            if (lf[9:8] == 2'b00) oc = 1;
            do_op(oc, int'(lf[6:4]), mk(1000 + n), lf[11] | lf[12]);
        end
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule